// File: doc/BRIEF.md
# Recirculating Serial Word-Loop Memory

This block models a rotating delay-line store as a bank of bit-serial loops holding 24-bit words. There are five loops: four rapid loops of 1, 4, 8 and 16 words and one long main channel of `MAIN_WORDS` words. A free-running timebase splits time into slots of 27 bit clocks. Each slot carries 24 data bits, least significant bit first, followed by 3 idle timing bits. A sector counter names the word slot that is passing under the read point.

A requester presents a loop select, a word address, a read/write flag and, for writes, a parallel data word. The block then waits until the addressed word rotates under one of the loop's read taps. During that slot it either streams the word out one bit per clock or overwrites it one bit per clock. The 8-word loop has two taps 4 words apart, and the 16-word loop has two taps 8 words apart, so the longest wait is capped below the loop length. When the access ends the block pulses a done strobe and reports how many slot boundaries it waited. The main channel can be made read-only through a write-enable input.

Top module: `wl_loop_mem`

## Requirements
- R1: Reset (rst_ni low) clears every stored word to zero, sets sector_o to 0 and holds busy_o, done_o, prot_o and rvalid_o low.
- R2: A slot lasts WORD_W+GAP_W = 27 clocks. sector_o increases by one at every slot boundary and wraps from MAIN_WORDS-1 to 0.
- R3: A request is accepted on a clock edge where req_i is high, busy_o is low and sel_i is 0..4 (0 = 1-word loop, 1 = 4-word, 2 = 8-word, 3 = 16-word, 4 = main channel). busy_o is high from the next cycle. If sel_i is 5..7 the request is ignored. A request made while busy_o is high is ignored.
- R4: Let s be the sector shown in the cycle in which a request is accepted on the first bit of a slot. The transfer then starts on the first bit of slot s+W, where W = ((a − s − 1) mod SPAN) + 1, a is the address and SPAN is 1, 4, 4, 8 and MAIN_WORDS for selects 0..4.
- R5: wait_o, read while done_o is high, equals W. W is always between 1 and SPAN for the selected loop.
- R6: A read drives rvalid_o high for exactly 24 consecutive cycles. rbit_o carries the stored word least significant bit first.
- R7: A write stores wdata_i into the addressed word, and a later read returns that value. No other word in any loop changes.
- R8: done_o is high for one cycle, the cycle after the last data bit. busy_o is low in that same cycle.
- R9: A write to a loop whose PROT_MASK bit is set (by default only the main channel) while wen_i is low at acceptance leaves the stored word unchanged. It still completes, and prot_o is high together with done_o for that one cycle.
- R10: Loops whose PROT_MASK bit is clear accept writes whatever the level of wen_i.
- R11: The address is taken modulo the depth of the selected loop. Upper address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request |
| sel_i | input | 3 | Loop select (0..4 valid) |
| addr_i | input | clog2(MAIN_WORDS) | Word address |
| we_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | WORD_W | Write word, sampled at acceptance |
| wen_i | input | 1 | Write enable for protected loops |
| busy_o | output | 1 | Access in progress |
| rbit_o | output | 1 | Serial read bit |
| rvalid_o | output | 1 | rbit_o carries a data bit |
| done_o | output | 1 | One-cycle completion strobe |
| prot_o | output | 1 | Write was blocked by protection |
| wait_o | output | clog2(MAIN_WORDS+1) | Slot boundaries waited by the last access |
| sector_o | output | clog2(MAIN_WORDS) | Word slot under the read point |

## Verification
The bench builds the block with MAIN_WORDS = 32 and keeps the default protection mask, which guards only the main channel. The shorter main channel makes the sector wrap and the full main-channel wait range reachable in a few thousand clocks. Main-channel addresses near both ends of the wait range are tested, along with the 8- and 16-word loops, where the tap spacing shows up in the measured wait. Address aliasing is exercised on the 4-word and 8-word loops by using addresses above their depth.

// File: rtl/wl_pkg.sv
package wl_pkg;
  localparam int NUM_LOOPS = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_XFER} wl_state_e;

  function automatic int loop_depth(int k, int main_words);
    case (k)
      0:       return 1;
      1:       return 4;
      2:       return 8;
      3:       return 16;
      default: return main_words;
    endcase
  endfunction

  function automatic int loop_taps(int k);
    return (k == 2 || k == 3) ? 2 : 1;
  endfunction

  // words between consecutive taps: worst-case wait in slots
  function automatic int loop_span(int k, int main_words);
    return loop_depth(k, main_words) / loop_taps(k);
  endfunction
endpackage

// File: rtl/wl_timebase.sv
module wl_timebase #(
  parameter int SLOT_W = 27,
  parameter int BW     = 5,
  parameter int AW     = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [BW-1:0] bit_cnt_o,
  output logic          slot_end_o,
  output logic [AW-1:0] sector_o,
  output logic [AW-1:0] sector_next_o
);
  logic [BW-1:0] bit_q;
  logic [AW-1:0] sec_q;

  assign slot_end_o    = (bit_q == BW'(SLOT_W - 1));
  assign sector_next_o = sec_q + 1'b1;
  assign bit_cnt_o     = bit_q;
  assign sector_o      = sec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      sec_q <= '0;
    end else if (slot_end_o) begin
      bit_q <= '0;
      sec_q <= sector_next_o;
    end else begin
      bit_q <= bit_q + 1'b1;
    end
  end
endmodule

// File: rtl/wl_loop.sv
module wl_loop #(
  parameter int W     = 24,
  parameter int DEPTH = 8,
  parameter int SPAN  = 4,
  parameter int AW    = 7,
  parameter int BW    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] sector_next_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] bit_idx_i,
  input  logic          wr_en_i,
  input  logic          wr_bit_i,
  output logic          hit_o,
  output logic          rd_bit_o
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [IW-1:0] idx;
  logic          unused_ok;

  assign unused_ok = ^{addr_i, sector_next_i};

  generate
    if (DEPTH == 1) begin : g_one
      assign idx = '0;
    end else begin : g_many
      assign idx = addr_i[IW-1:0];
    end

    if (SPAN == 1) begin : g_every
      assign hit_o = 1'b1;
    end else begin : g_tap
      localparam int SW = $clog2(SPAN);
      // a tap lands on the word whenever the low sector bits match
      assign hit_o = (sector_next_i[SW-1:0] == addr_i[SW-1:0]);
    end
  endgenerate

  assign rd_bit_o = mem_q[idx][bit_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[idx][bit_idx_i] <= wr_bit_i;
    end
  end
endmodule

// File: rtl/wl_ctrl.sv
module wl_ctrl
  import wl_pkg::*;
#(
  parameter int             WORD_W    = 24,
  parameter int             AW        = 7,
  parameter int             BW        = 5,
  parameter int             WTW       = 8,
  parameter logic [NUM_LOOPS-1:0] PROT_MASK = 5'b10000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [2:0]           sel_i,
  input  logic [AW-1:0]        addr_i,
  input  logic                 we_i,
  input  logic [WORD_W-1:0]    wdata_i,
  input  logic                 wen_i,
  input  logic [BW-1:0]        bit_cnt_i,
  input  logic                 slot_end_i,
  input  logic [NUM_LOOPS-1:0] hit_i,
  input  logic [NUM_LOOPS-1:0] rd_bit_i,
  output logic [AW-1:0]        addr_o,
  output logic [NUM_LOOPS-1:0] wr_en_o,
  output logic                 wr_bit_o,
  output logic                 busy_o,
  output logic                 rbit_o,
  output logic                 rvalid_o,
  output logic                 done_o,
  output logic                 prot_o,
  output logic [WTW-1:0]       wait_o
);
  wl_state_e          st_q;
  logic [2:0]         sel_q;
  logic [AW-1:0]      addr_q;
  logic               we_q, blk_q, done_q, prot_q;
  logic [WORD_W-1:0]  wdata_q;
  logic [WTW-1:0]     wait_q;
  logic               in_xfer;

  assign in_xfer  = (st_q == ST_XFER);
  assign busy_o   = (st_q != ST_IDLE);
  assign rvalid_o = in_xfer && !we_q;
  assign rbit_o   = rd_bit_i[sel_q];
  assign wr_bit_o = wdata_q[bit_cnt_i];
  assign addr_o   = addr_q;
  assign done_o   = done_q;
  assign prot_o   = prot_q;
  assign wait_o   = wait_q;

  generate
    for (genvar k = 0; k < NUM_LOOPS; k++) begin : g_wen
      assign wr_en_o[k] = in_xfer && we_q && !blk_q && (sel_q == 3'(k));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      sel_q   <= '0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      blk_q   <= 1'b0;
      wdata_q <= '0;
      wait_q  <= '0;
      done_q  <= 1'b0;
      prot_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      prot_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_i && (sel_i < 3'(NUM_LOOPS))) begin
            st_q    <= ST_WAIT;
            sel_q   <= sel_i;
            addr_q  <= addr_i;
            we_q    <= we_i;
            wdata_q <= wdata_i;
            wait_q  <= '0;
            blk_q   <= we_i && !wen_i && PROT_MASK[sel_i];
          end
        end
        ST_WAIT: begin
          if (slot_end_i) begin
            wait_q <= wait_q + 1'b1;
            if (hit_i[sel_q]) st_q <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (bit_cnt_i == BW'(WORD_W - 1)) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
            prot_q <= blk_q;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wl_loop_mem.sv
module wl_loop_mem
  import wl_pkg::*;
#(
  parameter int             WORD_W     = 24,
  parameter int             GAP_W      = 3,
  parameter int             MAIN_WORDS = 128,
  parameter logic [NUM_LOOPS-1:0] PROT_MASK = 5'b10000,
  localparam int            AW         = $clog2(MAIN_WORDS),
  localparam int            WTW        = $clog2(MAIN_WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        sel_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              wen_i,
  output logic              busy_o,
  output logic              rbit_o,
  output logic              rvalid_o,
  output logic              done_o,
  output logic              prot_o,
  output logic [WTW-1:0]    wait_o,
  output logic [AW-1:0]     sector_o
);
  localparam int SLOT_W = WORD_W + GAP_W;
  localparam int BW     = $clog2(SLOT_W);

  logic [BW-1:0]        bit_cnt;
  logic                 slot_end;
  logic [AW-1:0]        sector_next;
  logic [AW-1:0]        addr_q;
  logic [NUM_LOOPS-1:0] hit, rd_bit, wr_en;
  logic                 wr_bit;

  wl_timebase #(.SLOT_W(SLOT_W), .BW(BW), .AW(AW)) i_timebase (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_cnt_o    (bit_cnt),
    .slot_end_o   (slot_end),
    .sector_o     (sector_o),
    .sector_next_o(sector_next)
  );

  generate
    for (genvar k = 0; k < NUM_LOOPS; k++) begin : g_loop
      wl_loop #(
        .W    (WORD_W),
        .DEPTH(loop_depth(k, MAIN_WORDS)),
        .SPAN (loop_span(k, MAIN_WORDS)),
        .AW   (AW),
        .BW   (BW)
      ) i_loop (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .sector_next_i(sector_next),
        .addr_i       (addr_q),
        .bit_idx_i    (bit_cnt),
        .wr_en_i      (wr_en[k]),
        .wr_bit_i     (wr_bit),
        .hit_o        (hit[k]),
        .rd_bit_o     (rd_bit[k])
      );
    end
  endgenerate

  wl_ctrl #(
    .WORD_W(WORD_W), .AW(AW), .BW(BW), .WTW(WTW), .PROT_MASK(PROT_MASK)
  ) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .sel_i     (sel_i),
    .addr_i    (addr_i),
    .we_i      (we_i),
    .wdata_i   (wdata_i),
    .wen_i     (wen_i),
    .bit_cnt_i (bit_cnt),
    .slot_end_i(slot_end),
    .hit_i     (hit),
    .rd_bit_i  (rd_bit),
    .addr_o    (addr_q),
    .wr_en_o   (wr_en),
    .wr_bit_o  (wr_bit),
    .busy_o    (busy_o),
    .rbit_o    (rbit_o),
    .rvalid_o  (rvalid_o),
    .done_o    (done_o),
    .prot_o    (prot_o),
    .wait_o    (wait_o)
  );
endmodule

// File: rtl/wl_loop_mem_chk.sv
module wl_loop_mem_chk #(
  parameter int MAIN_WORDS = 128,
  parameter int AW         = 7,
  parameter int WTW        = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_i,
  input logic [2:0]     sel_i,
  input logic           busy_o,
  input logic           rvalid_o,
  input logic           done_o,
  input logic           prot_o,
  input logic [WTW-1:0] wait_o,
  input logic [AW-1:0]  sector_o
);
  logic [31:0] span_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) span_q <= 32'd1;
    else if (req_i && !busy_o && sel_i < 3'd5)
      span_q <= 32'(wl_pkg::loop_span(int'(sel_i), MAIN_WORDS));
  end

  AST_SECTOR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sector_o != $past(sector_o)) |-> (sector_o == $past(sector_o) + 1'b1)); // R2

  AST_BAD_SEL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && sel_i > 3'd4) |=> !busy_o); // R3

  AST_WAIT_IN_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (wait_o >= WTW'(1) && 32'(wait_o) <= span_q)); // R5

  AST_RVALID_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> busy_o); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R8

  AST_PROT_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_o |-> done_o); // R9
endmodule

bind wl_loop_mem wl_loop_mem_chk #(.MAIN_WORDS(MAIN_WORDS), .AW(AW), .WTW(WTW)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .sel_i   (sel_i),
  .busy_o  (busy_o),
  .rvalid_o(rvalid_o),
  .done_o  (done_o),
  .prot_o  (prot_o),
  .wait_o  (wait_o),
  .sector_o(sector_o)
);

// File: tb/test_wl_loop_mem.sv
module test_wl_loop_mem;
  localparam int MW   = 32;
  localparam int AW   = $clog2(MW);
  localparam int WTW  = $clog2(MW + 1);
  localparam int SLOT = 27;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0;
  logic [2:0]        sel_i = '0;
  logic [AW-1:0]     addr_i = '0;
  logic              we_i = 1'b0;
  logic [23:0]       wdata_i = '0;
  logic              wen_i = 1'b0;
  logic              busy_o, rbit_o, rvalid_o, done_o, prot_o;
  logic [WTW-1:0]    wait_o;
  logic [AW-1:0]     sector_o;

  wl_loop_mem #(.MAIN_WORDS(MW)) i_wl_loop_mem (.*);

  always #10 clk_i = ~clk_i;

  typedef struct {
    int          sel;
    bit          is_wr;
    logic [23:0] word;
    int          wt;
    bit          prot;
    longint      start;
  } item_t;

  item_t       exp_q[$];
  logic [23:0] model [5][MW];
  longint      cyc = 0;
  int          n_tests = 0;
  int          n_fail = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic int depth_of(int k);
    case (k) 0: return 1; 1: return 4; 2: return 8; 3: return 16; default: return MW; endcase
  endfunction

  function automatic int span_of(int k);
    return (k == 2 || k == 3) ? depth_of(k) / 2 : depth_of(k);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic align_slot();
    logic [AW-1:0] prev;
    prev = sector_o;
    forever begin
      @(negedge clk_i);
      if (sector_o != prev) break;
      prev = sector_o;
    end
  endtask

  // driver: computes expectation from the requirements and pushes it
  task automatic access(int sel, int addr, bit wr, logic [23:0] data, bit wen, bit poke);
    item_t it;
    int s, am, e;
    align_slot();
    s  = int'(sector_o);
    am = addr % depth_of(sel);
    e  = span_of(sel);
    it.sel   = sel;
    it.is_wr = wr;
    it.wt    = (((am - s - 1) % e) + e) % e + 1;
    it.start = cyc + longint'(SLOT * it.wt);
    it.prot  = wr && !wen && (sel == 4);
    if (wr) begin
      if (!it.prot) model[sel][am] = data;
      it.word = data;
    end else begin
      it.word = model[sel][am];
    end
    exp_q.push_back(it);
    req_i = 1'b1; sel_i = 3'(sel); addr_i = AW'(addr); we_i = wr; wdata_i = data; wen_i = wen;
    @(negedge clk_i);
    req_i = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk_i);
      req_i = 1'b1; sel_i = 3'd0; we_i = 1'b1; wdata_i = 24'hDEAD00; wen_i = 1'b1;
      @(negedge clk_i);
      req_i = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk_i);
  endtask

  // monitor: collects serial bits and pops expectations at done
  initial begin
    int          nb = 0;
    longint      first = 0;
    logic [23:0] got = '0;
    item_t       it;
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        if (rvalid_o) begin
          if (nb == 0) first = cyc;
          if (nb < 24) got[nb] = rbit_o;
          nb++;
        end
        if (prot_o && !done_o) check(0, "R9", "prot without done", 1, 0);
        if (done_o) begin
          if (exp_q.size() == 0) begin
            check(0, "R3", "unexpected completion", 1, 0);
          end else begin
            it = exp_q.pop_front();
            check(wait_o == WTW'(it.wt), "R5", "wait_o", wait_o, it.wt);
            check(cyc == it.start + 24, "R4", "done cycle", cyc, it.start + 24);
            check(busy_o == 1'b0, "R8", "busy at done", busy_o, 0);
            check(prot_o == it.prot, "R9", "prot_o", prot_o, it.prot);
            if (it.is_wr) begin
              check(nb == 0, "R6", "rvalid on write", nb, 0);
            end else begin
              check(nb == 24, "R6", "serial bit count", nb, 24);
              check(first == it.start, "R4", "first bit cycle", first, it.start);
              check(got == it.word, "R7", "read word", got, it.word);
            end
          end
          nb = 0;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int     bad_steps, busy_seen;
    bit     wrapped;
    longint t_prev;
    logic [AW-1:0] s_prev;
    for (int k = 0; k < 5; k++)
      for (int a = 0; a < MW; a++) model[k][a] = '0;

    repeat (3) @(negedge clk_i);
    check(sector_o == '0, "R1", "reset sector", sector_o, 0);
    check(!busy_o && !done_o && !prot_o && !rvalid_o, "R1", "reset outputs",
          {busy_o, done_o, prot_o, rvalid_o}, 0);
    rst_ni = 1'b1;

    // R2: slot length and sector stepping with wrap
    align_slot();
    t_prev = cyc; s_prev = sector_o; bad_steps = 0; wrapped = 0;
    for (int n = 0; n < MW + 2; n++) begin
      align_slot();
      if (cyc - t_prev != SLOT) bad_steps++;
      if (sector_o != s_prev + 1'b1) bad_steps++;
      if (s_prev == AW'(MW - 1) && sector_o == '0) wrapped = 1;
      t_prev = cyc; s_prev = sector_o;
    end
    check(bad_steps == 0, "R2", "slot/sector steps", bad_steps, 0);
    check(wrapped, "R2", "sector wrap", wrapped, 1);

    // R1: contents zero after reset
    access(0, 0, 0, '0, 0, 0);
    access(2, 7, 0, '0, 0, 0);
    access(4, 31, 0, '0, 0, 0);

    // R7 / R10: writes into every loop, rapid loops with wen low
    access(0, 0, 1, 24'hA5A5A5, 0, 0);
    access(1, 3, 1, 24'h123456, 0, 0);
    access(2, 5, 1, 24'hFEDCBA, 0, 0);
    access(3, 11, 1, 24'h0F0F0F, 0, 0);
    access(4, 17, 1, 24'h800001, 1, 0);
    access(4, 0, 1, 24'h7FFFFF, 1, 0);
    access(0, 0, 0, '0, 0, 0);
    access(1, 3, 0, '0, 0, 0);
    access(2, 5, 0, '0, 0, 0);
    access(3, 11, 0, '0, 0, 0);
    access(3, 3, 0, '0, 0, 0);
    access(4, 17, 0, '0, 0, 0);
    access(4, 0, 0, '0, 0, 0);
    access(4, 16, 0, '0, 0, 0);

    // R5: tap spacing on the 8- and 16-word loops
    for (int a = 0; a < 8; a++) access(2, a, 0, '0, 0, 0);
    for (int a = 8; a < 16; a += 3) access(3, a, 0, '0, 0, 0);

    // R9: protected main-channel write
    access(4, 17, 1, 24'h000000, 0, 0);
    access(4, 17, 0, '0, 0, 0);

    // R11: address aliasing modulo loop depth
    access(1, 6, 1, 24'h3C3C3C, 0, 0);
    access(1, 2, 0, '0, 0, 0);
    access(2, 13, 1, 24'h55AA55, 0, 0);
    access(2, 5, 0, '0, 0, 0);

    // R3: request during busy ignored, then invalid select ignored
    access(4, 0, 0, '0, 0, 1);
    access(0, 0, 0, '0, 0, 0);
    align_slot();
    req_i = 1'b1; sel_i = 3'd5; we_i = 1'b0;
    @(negedge clk_i);
    req_i = 1'b0;
    busy_seen = 0;
    for (int n = 0; n < 2 * SLOT; n++) begin
      if (busy_o) busy_seen++;
      @(negedge clk_i);
    end
    check(busy_seen == 0, "R3", "invalid select busy cycles", busy_seen, 0);

    access(0, 0, 1, 24'hFFFFFF, 0, 0);
    access(0, 0, 0, '0, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule